// File: doc/BRIEF.md
# Character Display Host Bus Interface

This block is the host-facing front end of a character display controller. A microprocessor talks to it with a register-select line, a read/write line and an enable strobe, over an eight-bit data bus. Writes with select low carry commands; writes and reads with select high move data bytes to and from the display memories. Reads with select low return a status byte: the busy flag and the address counter. The memory arrays, the command execution behind the busy flag and the panel drive sit outside. The block reaches the memories through a simple port: a read address, a select between the display memory and the glyph memory, a write strobe and a read-data input that follows the address.

The bus runs either in full-byte mode or in nibble mode. In nibble mode every byte crosses the upper four data lines in two strobes. A mode command switches between the two modes at run time. After every executed command or data access the block raises a busy flag for a set number of internal clocks. While it is busy it drops every strobe except a status read. Data reads are served from a prefetched data register. Only an address load, a cursor move or a data read refreshes that register. A data write leaves it alone.

Top module: `chardisp_hostif`

## Requirements
- R1: An enable strobe with select=0 and read=0 is a command. With select=0 and read=1 it returns status, busy on bit 7 and the 7-bit address counter on bits 6..0. With select=1 it moves a data byte. After reset the status reads 0x00.
- R2: `dbOe` is high only while the enable strobe is high with read=1. In nibble mode the driven byte carries its payload on bits 7..4 and zeros on bits 3..0.
- R3: In nibble mode each byte takes two strobes, high nibble first, then low nibble. This holds for commands, data and status alike.
- R4: After reset the bus is in full-byte mode. A command of the form 001dxxxx selects full-byte mode when d (bit 4) is 1 and nibble mode when d is 0, and takes effect from the next strobe. Selecting full-byte mode returns the nibble phase to the high half.
- R5: While busy, every strobe other than a status read is dropped. It does not write memory, move the address counter or advance the nibble phase.
- R6: Busy is set from the clock after an accepted strobe's falling enable edge. It lasts LONG_CYC clocks for the clear command (0x01) and the home commands (0x02, 0x03), and SHORT_CYC clocks for every other command and data access. Status reads never set it.
- R7: The command 1aaaaaaa loads the 7-bit display address. The command 01aaaaaa loads the 6-bit glyph address. Both select the addressed memory and prefetch the byte at the new address into the data register.
- R8: A data read returns the data register. Then the address counter steps and the register is reloaded from the new address. In glyph memory the counter wraps within 6 bits.
- R9: A data write stores the byte at the address counter and then steps the counter. The data register keeps its old contents.
- R10: The command 000001ds sets the step direction: d (bit 1) = 1 counts up, d = 0 counts down. After reset the counter counts up.
- R11: The command 0001 0 r x x moves the cursor: r (bit 2) = 1 adds one to the counter, r = 0 subtracts one, and the data register is reloaded. The command 0001 1 x x x shifts the display and leaves the counter unchanged.
- R12: Write data, select and read lines are captured at the falling edge of the enable strobe, not at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| busRs | input | 1 | Register select: 0 command/status, 1 data |
| busRw | input | 1 | 1 read, 0 write |
| busE | input | 1 | Enable strobe, sampled by clk |
| dbIn | input | 8 | Data bus from the host |
| dbOut | output | 8 | Data bus toward the host |
| dbOe | output | 1 | Drive enable for dbOut |
| memAddr | output | 7 | Memory address (address counter) |
| memCgSel | output | 1 | 1 selects glyph memory, 0 display memory |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write byte |
| memRdData | input | 8 | Memory read byte at memAddr |

## Verification
Two events can fall together: a host strobe arriving while the busy counter of the previous access is still running. A status read must be answered in that state, while anything else must vanish without side effects. The bench provokes this by issuing status reads, address loads, data writes and stray half-byte strobes back to back, without polling. It then judges the outcome from the address counter, the memory contents and the alignment of later nibble reads. A second case is the data register reload, which lands right after the counter steps. The bench checks this by sweeping every display and glyph address and comparing each read with the arithmetic fill pattern at that address and at the next one.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  // strobes from the control unit to the datapath, one cycle wide each
  typedef struct packed {
    logic hiCapture;  // keep the high nibble of a split write
    logic acLoad;     // load address counter from the assembled byte
    logic acLoadCg;   // the load targets glyph memory
    logic acStep;     // step address counter
    logic acDown;     // step direction is down
    logic acClear;    // counter to zero, display memory selected
    logic drReload;   // refill the data register from memory
    logic memWr;      // write the assembled byte to memory
  } dpStrobe_t;

endpackage

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int SHORT_CYC = 16,
  parameter int LONG_CYC  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRs,
  input  logic       busRw,
  input  logic       busE,
  input  logic [7:0] fullByte,
  output dpStrobe_t  strb,
  output logic       nibMode,
  output logic       lowPhase,
  output logic       busy
);

  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic             ePrev;
  logic             fall;
  logic             isStatus;
  logic             accept;
  logic             complete;
  logic             firstHalf;
  logic             incDir;
  logic             reloadPend;
  logic [CNT_W-1:0] busyCnt;

  // decode results
  logic cLoad, cCg, cStep, cDown, cClear, cReload, cLong, cFunc, cEntry, cWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ePrev <= 1'b0;
    else       ePrev <= busE;
  end

  assign fall      = ePrev & ~busE;
  assign isStatus  = ~busRs & busRw;
  assign busy      = (busyCnt != '0);
  assign accept    = fall & (isStatus | ~busy);
  assign complete  = accept & (~nibMode | lowPhase);
  assign firstHalf = accept & nibMode & ~lowPhase;

  always_comb begin
    cLoad = 1'b0; cCg = 1'b0; cStep = 1'b0; cDown = 1'b0; cClear = 1'b0;
    cReload = 1'b0; cLong = 1'b0; cFunc = 1'b0; cEntry = 1'b0; cWrite = 1'b0;
    if (complete && !busRs && !busRw) begin
      casez (fullByte)
        8'b1???????: begin cLoad = 1'b1; cReload = 1'b1; end
        8'b01??????: begin cLoad = 1'b1; cCg = 1'b1; cReload = 1'b1; end
        8'b001?????: cFunc = 1'b1;
        8'b0001????: begin
          if (!fullByte[3]) begin
            cStep = 1'b1; cDown = ~fullByte[2]; cReload = 1'b1;
          end
        end
        8'b000001??: cEntry = 1'b1;
        8'b0000001?: begin cClear = 1'b1; cLong = 1'b1; end
        8'b00000001: begin cClear = 1'b1; cLong = 1'b1; end
        default: ;
      endcase
    end else if (complete && busRs && busRw) begin
      cStep = 1'b1; cDown = ~incDir; cReload = 1'b1;
    end else if (complete && busRs && !busRw) begin
      cWrite = 1'b1; cStep = 1'b1; cDown = ~incDir;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibMode    <= 1'b0;
      lowPhase   <= 1'b0;
      incDir     <= 1'b1;
      reloadPend <= 1'b0;
      busyCnt    <= '0;
    end else begin
      reloadPend <= cReload;
      if (cFunc) nibMode <= ~fullByte[4];
      if (cEntry) incDir <= fullByte[1];
      if (cFunc && fullByte[4]) lowPhase <= 1'b0;
      else if (firstHalf)       lowPhase <= 1'b1;
      else if (complete)        lowPhase <= 1'b0;
      if (complete && !isStatus) begin
        if (cLong) busyCnt <= CNT_W'(LONG_CYC);
        else       busyCnt <= CNT_W'(SHORT_CYC);
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.hiCapture = firstHalf & ~busRw;
    strb.acLoad    = cLoad;
    strb.acLoadCg  = cCg;
    strb.acStep    = cStep;
    strb.acDown    = cDown;
    strb.acClear   = cClear;
    strb.drReload  = reloadPend;
    strb.memWr     = cWrite;
  end

endmodule

// File: rtl/chardisp_dpath.sv
module chardisp_dpath
  import chardisp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              nibMode,
  input  logic              lowPhase,
  input  logic              busy,
  input  logic              busRs,
  input  logic              busRw,
  input  logic              busE,
  input  logic [DATA_W-1:0] dbIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] fullByte,
  output logic [DATA_W-1:0] dbOut,
  output logic              dbOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCgSel,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData
);

  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0]  hiNib;
  logic [ADDR_W-1:0] ac;
  logic [ADDR_W-1:0] acStepped;
  logic [ADDR_W-1:0] acNext;
  logic              cgSel;
  logic [DATA_W-1:0] dr;
  logic [DATA_W-1:0] outByte;

  assign fullByte = nibMode ? {hiNib, dbIn[DATA_W-1:NIB_W]} : dbIn;

  always_comb begin
    acStepped = strb.acDown ? ac - 1'b1 : ac + 1'b1;
    acNext    = acStepped;
    if (cgSel) acNext[ADDR_W-1] = 1'b0;  // glyph addresses wrap in 6 bits
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib <= '0;
      ac    <= '0;
      cgSel <= 1'b0;
      dr    <= '0;
    end else begin
      if (strb.hiCapture) hiNib <= dbIn[DATA_W-1:NIB_W];
      if (strb.acClear) begin
        ac    <= '0;
        cgSel <= 1'b0;
      end else if (strb.acLoad) begin
        cgSel <= strb.acLoadCg;
        if (strb.acLoadCg) ac <= {1'b0, fullByte[ADDR_W-2:0]};
        else               ac <= fullByte[ADDR_W-1:0];
      end else if (strb.acStep) begin
        ac <= acNext;
      end
      if (strb.drReload) dr <= memRdData;
    end
  end

  assign memAddr   = ac;
  assign memCgSel  = cgSel;
  assign memWrEn   = strb.memWr;
  assign memWrData = fullByte;

  assign outByte = busRs ? dr : {busy, ac};
  always_comb begin
    if (!nibMode)     dbOut = outByte;
    else if (lowPhase) dbOut = {outByte[NIB_W-1:0], {NIB_W{1'b0}}};
    else               dbOut = {outByte[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
  end
  assign dbOe = busE & busRw;

endmodule

// File: rtl/chardisp_hostif.sv
module chardisp_hostif
  import chardisp_pkg::*;
#(
  parameter int SHORT_CYC = 16,
  parameter int LONG_CYC  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRs,
  input  logic       busRw,
  input  logic       busE,
  input  logic [7:0] dbIn,
  output logic [7:0] dbOut,
  output logic       dbOe,
  output logic [6:0] memAddr,
  output logic       memCgSel,
  output logic       memWrEn,
  output logic [7:0] memWrData,
  input  logic [7:0] memRdData
);

  dpStrobe_t  strb;
  logic       nibMode;
  logic       lowPhase;
  logic       busy;
  logic [7:0] fullByte;

  chardisp_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw), .busE(busE),
    .fullByte(fullByte), .strb(strb), .nibMode(nibMode),
    .lowPhase(lowPhase), .busy(busy)
  );

  chardisp_dpath #(.DATA_W(8), .ADDR_W(7)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .nibMode(nibMode),
    .lowPhase(lowPhase), .busy(busy), .busRs(busRs), .busRw(busRw),
    .busE(busE), .dbIn(dbIn), .memRdData(memRdData), .fullByte(fullByte),
    .dbOut(dbOut), .dbOe(dbOe), .memAddr(memAddr), .memCgSel(memCgSel),
    .memWrEn(memWrEn), .memWrData(memWrData)
  );

endmodule

// File: rtl/chardisp_hostif_chk.sv
module chardisp_hostif_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busE,
  input logic       busRw,
  input logic       busRs,
  input logic       dbOe,
  input logic [7:0] dbOut,
  input logic [6:0] memAddr,
  input logic       memWrEn,
  input logic       busy,
  input logic       nibMode
);

  // drive only during a read strobe
  assert_oe_read_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    dbOe |-> (busE && busRw));

  // nibble mode leaves the low lines at zero
  assert_nibble_low_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dbOe && nibMode) |-> (dbOut[3:0] == 4'h0));

  // full-byte status is busy over the address counter
  assert_status_layout_R1: assert property (@(posedge clk) disable iff (!rstN)
    (dbOe && !busRs && !nibMode) |-> (dbOut == {busy, memAddr}));

  // no memory write accepted while busy
  assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !busy);

  // a data write makes the block busy on the next clock
  assert_write_sets_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> busy);

endmodule

bind chardisp_hostif chardisp_hostif_chk u_chk (
  .clk(clk), .rstN(rstN), .busE(busE), .busRw(busRw), .busRs(busRs),
  .dbOe(dbOe), .dbOut(dbOut), .memAddr(memAddr), .memWrEn(memWrEn),
  .busy(busy), .nibMode(nibMode)
);

// File: tb/chardisp_hostif_tb.sv
`timescale 1ns/1ps
module chardisp_hostif_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busRs, busRw, busE;
  logic [7:0] dbIn, dbOut, memWrData, memRdData;
  logic       dbOe, memCgSel, memWrEn;
  logic [6:0] memAddr;

  always #2 clk = ~clk;

  chardisp_hostif #(.SHORT_CYC(16), .LONG_CYC(40)) u_dut (
    .clk(clk), .rstN(rstN), .busRs(busRs), .busRw(busRw), .busE(busE),
    .dbIn(dbIn), .dbOut(dbOut), .dbOe(dbOe), .memAddr(memAddr),
    .memCgSel(memCgSel), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  // memory model with arithmetic fill
  logic [7:0] ddMem [128];
  logic [7:0] cgMem [64];
  assign memRdData = memCgSel ? cgMem[memAddr[5:0]] : ddMem[memAddr];
  always @(posedge clk) begin
    if (memWrEn) begin
      if (memCgSel) cgMem[memAddr[5:0]] <= memWrData;
      else          ddMem[memAddr]      <= memWrData;
    end
  end

  function automatic logic [7:0] ddFill(input int i);
    return 8'((i % 128) * 7 + 3);
  endfunction
  function automatic logic [7:0] cgFill(input int i);
    return 8'(i % 64) ^ 8'h5A;
  endfunction

  int   total = 0;
  int   bad = 0;
  bit   m4 = 1'b0;
  bit   done = 1'b0;
  logic lastOe;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] din,
                      output logic [7:0] dout);
    @(negedge clk); busRs = rs; busRw = rw; dbIn = din; busE = 1'b0;
    @(negedge clk); busE = 1'b1;
    @(negedge clk); dout = dbOut; lastOe = dbOe;
    @(negedge clk); busE = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic rs, input logic [7:0] b);
    logic [7:0] d;
    if (m4) begin
      xfer(rs, 1'b0, {b[7:4], 4'h0}, d);
      xfer(rs, 1'b0, {b[3:0], 4'h0}, d);
    end else begin
      xfer(rs, 1'b0, b, d);
    end
  endtask

  task automatic rd(input logic rs, output logic [7:0] b);
    logic [7:0] h, l;
    if (m4) begin
      xfer(rs, 1'b1, 8'h00, h);
      xfer(rs, 1'b1, 8'h00, l);
      b = {h[7:4], l[7:4]};
    end else begin
      xfer(rs, 1'b1, 8'h00, b);
    end
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rd(1'b0, s);
      if (!s[7]) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) ddMem[i] = ddFill(i);
    for (int i = 0; i < 64; i++)  cgMem[i] = cgFill(i);
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    rstN = 1'b0; busRs = 1'b0; busRw = 1'b0; busE = 1'b0; dbIn = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset oe", {7'd0, dbOe}, 8'h00);
    rd(1'b0, s);
    check("R1 R4 reset status", s, 8'h00);
    check("R2 oe during read", {7'd0, lastOe}, 8'h01);

    // R7 R8: every display address
    for (int a = 0; a < 128; a++) begin
      wr(1'b0, 8'h80 | 8'(a));
      waitIdle();
      rd(1'b0, s);
      check("R7 ac load", s, 8'(a));
      rd(1'b1, d);
      check("R7 prefetch", d, ddFill(a));
      waitIdle();
      rd(1'b1, d);
      check("R8 reload next", d, ddFill(a + 1));
      waitIdle();
      rd(1'b0, s);
      check("R8 ac step", s, 8'((a + 2) % 128));
    end

    // R7 R8: every glyph address, wrap within 6 bits
    for (int a = 0; a < 64; a++) begin
      wr(1'b0, 8'h40 | 8'(a));
      waitIdle();
      rd(1'b1, d);
      check("R7 glyph prefetch", d, cgFill(a));
      waitIdle();
      rd(1'b0, s);
      check("R8 glyph step", s, 8'((a + 1) % 64));
    end

    // R9: write leaves data register stale
    wr(1'b0, 8'h90); waitIdle();
    wr(1'b1, 8'hC3);
    check("R2 no drive on write", {7'd0, lastOe}, 8'h00);
    waitIdle();
    check("R9 mem written", ddMem[16], 8'hC3);
    rd(1'b0, s);
    check("R9 ac step", s, 8'h11);
    rd(1'b1, d);
    check("R9 stale register", d, ddFill(16));
    waitIdle();

    // R10: count down
    wr(1'b0, 8'h04); waitIdle();
    wr(1'b0, 8'hA0); waitIdle();
    rd(1'b1, d); check("R10 first", d, ddFill(32)); waitIdle();
    rd(1'b1, d); check("R10 down reload", d, ddFill(31)); waitIdle();
    rd(1'b0, s); check("R10 down ac", s, 8'h1E);
    wr(1'b0, 8'h06); waitIdle();

    // R11: cursor and display shift
    wr(1'b0, 8'h85); waitIdle();
    wr(1'b0, 8'h14); waitIdle();
    rd(1'b0, s); check("R11 right ac", s, 8'h06);
    rd(1'b1, d); check("R11 right reload", d, ddFill(6)); waitIdle();
    wr(1'b0, 8'h10); waitIdle();
    rd(1'b0, s); check("R11 left ac", s, 8'h06);
    rd(1'b1, d); check("R11 left reload", d, ddFill(6)); waitIdle();
    wr(1'b0, 8'h18); waitIdle();
    rd(1'b0, s); check("R11 display shift keeps ac", s, 8'h07);

    // R5 R6: busy gating and durations
    wr(1'b0, 8'h85);
    rd(1'b0, s); check("R6 busy visible", s, 8'h85);
    wr(1'b0, 8'h90);
    wr(1'b1, 8'h77);
    waitIdle();
    rd(1'b0, s); check("R5 command dropped", s, 8'h05);
    check("R5 write dropped", ddMem[5], ddFill(5));
    wr(1'b0, 8'h02);
    repeat (20) @(negedge clk);
    rd(1'b0, s); check("R6 long busy", {7'd0, s[7]}, 8'h01);
    waitIdle();
    rd(1'b0, s); check("R6 home ac", s, 8'h00);
    wr(1'b0, 8'h90);
    repeat (20) @(negedge clk);
    rd(1'b0, s); check("R6 short busy over", s, 8'h10);

    // R3 R4: nibble mode
    wr(1'b0, 8'h20); m4 = 1'b1; waitIdle();
    wr(1'b0, 8'hB3); waitIdle();
    xfer(1'b0, 1'b1, 8'h00, d);
    check("R2 nibble low zero", {4'h0, d[3:0]}, 8'h00);
    check("R3 status high nibble", {4'h0, d[7:4]}, 8'h03);
    xfer(1'b0, 1'b1, 8'h00, d);
    check("R3 status low nibble", {4'h0, d[7:4]}, 8'h03);
    rd(1'b1, d); check("R3 nibble data read", d, ddFill(51)); waitIdle();
    rd(1'b0, s); check("R3 nibble ac", s, 8'h34);
    wr(1'b1, 8'h5E); waitIdle();
    check("R3 nibble data write", ddMem[52], 8'h5E);

    // R5: stray half while busy does not shift the phase
    wr(1'b0, 8'hC0);
    xfer(1'b0, 1'b0, 8'h90, d);
    waitIdle();
    rd(1'b0, s); check("R5 phase kept", s, 8'h40);

    // R4: back to full byte and again to nibble
    wr(1'b0, 8'h30); m4 = 1'b0; waitIdle();
    rd(1'b0, s); check("R4 full byte status", s, 8'h40);
    wr(1'b0, 8'h20); m4 = 1'b1; waitIdle();
    wr(1'b0, 8'h8A); waitIdle();
    rd(1'b0, s); check("R4 phase restart", s, 8'h0A);
    wr(1'b0, 8'h30); m4 = 1'b0; waitIdle();

    // R12: capture at the falling edge
    wr(1'b0, 8'hE0); waitIdle();
    @(negedge clk); busRs = 1'b1; busRw = 1'b0; dbIn = 8'h11; busE = 1'b0;
    @(negedge clk); busE = 1'b1;
    @(negedge clk); dbIn = 8'h22;
    @(negedge clk); busE = 1'b0;
    @(negedge clk);
    waitIdle();
    check("R12 falling edge capture", ddMem[96], 8'h22);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule